// File: doc/BRIEF.md
# Dual-Mode Fixed-Point SIMD ALU

This block is the integer execution unit of a 16-bit fixed-point datapath. It runs one operation per issued request on narrow 16-bit operands, on 32-bit words built from a pair of 16-bit registers (the odd register gives the upper half, the even register the lower half), or on two packed 16-bit lanes that share one 32-bit word. Add, subtract, the three bitwise logic operations, a signed-amount barrel shift and single-bit set, clear, toggle and test are all supported. Bit manipulation exists only at 16-bit width.

The surrounding pipeline hands over the opcode, the width mode, both register halves of each operand, an optional immediate and a combined shift-amount / bit-index field. The block computes the result combinationally and registers the result and its status flags, so every answer shows up one clock after the request. Requests the block cannot carry out raise an illegal flag instead of producing data.

Top module: `dmsimd_alu`

## Requirements
- R1: Result, flags and `illegal` are registered: they reflect the request presented with `in_valid` high at the previous rising edge, `out_valid` equals `in_valid` delayed by one clock, and reset clears every output to zero.
- R2: Mode encoding: 0 is narrow (A = `a_even`, B = `b_even`, result bits 31:16 read zero), 1 is wide (A = {`a_odd`,`a_even`}, B = {`b_odd`,`b_even`}), 2 is dual-lane (same word packing, two independent 16-bit lanes); mode 3 is illegal.
- R3: Opcode 0 adds and opcode 1 subtracts (A minus B) over the active width; the carry is the carry out of A + B, or of A + ~B + 1 for subtraction (1 means no borrow).
- R4: In mode 2 no carry crosses from the lower lane to the upper lane; `flag_c[1]`/`flag_v[1]` belong to the upper lane and `flag_c[0]`/`flag_v[0]` to the lower lane.
- R5: In modes 0 and 1, carry and signed overflow of the full active width appear in bit 0 of `flag_c`/`flag_v`, and bit 1 of both reads zero.
- R6: `flag_z` is set when the whole result is zero; `flag_n` is result bit 15 in mode 0 and bit 31 in modes 1 and 2.
- R7: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B, with carry and overflow flags zero.
- R8: Opcode 5 shifts A by the signed 6-bit `shamt`: positive shifts left filling zeros, negative shifts right arithmetically; in mode 2 both lanes shift by the same amount without crossing; carry and overflow read zero.
- R9: A shift amount outside -15..+15 in modes 0 and 2, or outside -31..+31 in mode 1, makes the request illegal.
- R10: Opcodes 8, 9 and 10 set, clear and toggle bit `shamt[3:0]` of `a_even` (bits 5:4 of `shamt` are ignored); `flag_t` reads zero.
- R11: Opcode 11 tests bit `shamt[3:0]` of `a_even`: the result is `a_even` unchanged and `flag_t` holds the selected bit.
- R12: A bit operation in mode 1 or 2, mode 3, or any opcode not listed is illegal: `illegal` is set, the result and every flag read zero.
- R13: With `use_imm` high, `imm` replaces B: as is in mode 0, sign-extended to 32 bits in mode 1, and copied into both lanes in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| mode | input | 2 | Width mode: narrow, wide pair, dual lane |
| a_odd | input | 16 | Upper half of operand A |
| a_even | input | 16 | Lower half of operand A |
| b_odd | input | 16 | Upper half of operand B |
| b_even | input | 16 | Lower half of operand B |
| use_imm | input | 1 | Take B from the immediate |
| imm | input | 16 | Immediate operand |
| shamt | input | 6 | Signed shift amount, or bit index in bits 3:0 |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 2 | Carry flags, one per lane |
| flag_v | output | 2 | Overflow flags, one per lane |
| flag_t | output | 1 | Bit-test flag |
| illegal | output | 1 | Request could not be executed |

## Verification
Random requests use operand halves biased toward 0x0000, 0x7FFF, 0x8000 and 0xFFFF, which is where a leaked carry between lanes, a wrong overflow sign rule or a missed sign extension of the immediate separate from correct behaviour. Shift amounts cover the whole signed 6-bit range, so the same stimulus tells left from arithmetic-right shifts and tells the narrow limit of 15 from the wide limit of 31. Directed cases pin carry propagation through a register pair against its absence between dual lanes, the bit test that must leave data untouched, and every route to the illegal flag.

// File: rtl/dmsimd_pkg.sv
package dmsimd_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_AND   = 4'h2,
        OP_OR    = 4'h3,
        OP_XOR   = 4'h4,
        OP_SHIFT = 4'h5,
        OP_BSET  = 4'h8,
        OP_BCLR  = 4'h9,
        OP_BTGL  = 4'hA,
        OP_BTST  = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        MODE_NARROW = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_DUAL   = 2'd2
    } alu_mode_e;

    // bit-unit sub-operation, taken from the low opcode bits
    typedef enum logic [1:0] {
        BIT_SET = 2'd0,
        BIT_CLR = 2'd1,
        BIT_TGL = 2'd2,
        BIT_TST = 2'd3
    } bit_sub_e;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff       = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        ovf         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/simd_shifter.sv
module simd_shifter import dmsimd_pkg::*; #(
    parameter  int LANE_W = 16,
    localparam int WORD_W = 2 * LANE_W,
    localparam int SH_W   = $clog2(WORD_W) + 1
) (
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [WORD_W-1:0] dout,
    output logic              out_of_range
);
    logic              neg;
    logic [SH_W-1:0]   mag;
    logic [WORD_W-1:0] wide_res;
    logic [WORD_W-1:0] lane_res;

    assign neg = amt[SH_W-1];
    assign mag = neg ? (~amt + 1'b1) : amt;

    assign wide_res = neg ? WORD_W'($signed(din) >>> mag) : (din << mag);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        assign lane_in = din[g*LANE_W +: LANE_W];
        assign lane_res[g*LANE_W +: LANE_W] =
            neg ? LANE_W'($signed(lane_in) >>> mag) : (lane_in << mag);
    end

    always_comb begin
        unique case (mode)
            MODE_WIDE: begin
                dout         = wide_res;
                out_of_range = (mag > SH_W'(WORD_W - 1));
            end
            MODE_DUAL: begin
                dout         = lane_res;
                out_of_range = (mag > SH_W'(LANE_W - 1));
            end
            default: begin
                dout         = {{LANE_W{1'b0}}, lane_res[LANE_W-1:0]};
                out_of_range = (mag > SH_W'(LANE_W - 1));
            end
        endcase
    end

    // R8
    always_comb begin
        if (!out_of_range && amt == '0) begin
            zero_shift_chk: assert (dout[LANE_W-1:0] == din[LANE_W-1:0]);
        end
    end
endmodule

// File: rtl/bit_unit.sv
module bit_unit import dmsimd_pkg::*; #(
    parameter  int LANE_W = 16,
    localparam int IDX_W  = $clog2(LANE_W)
) (
    input  logic [1:0]        sub_op,
    input  logic [LANE_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] dout,
    output logic              tbit
);
    logic [LANE_W-1:0] mask;

    always_comb begin
        mask = {{(LANE_W-1){1'b0}}, 1'b1} << idx;
        tbit = 1'b0;
        unique case (sub_op)
            BIT_SET: dout = din | mask;
            BIT_CLR: dout = din & ~mask;
            BIT_TGL: dout = din ^ mask;
            default: begin
                dout = din;
                tbit = |(din & mask);
            end
        endcase
    end
endmodule

// File: rtl/dmsimd_alu.sv
module dmsimd_alu import dmsimd_pkg::*; #(
    parameter  int LANE_W = 16,
    localparam int WORD_W = 2 * LANE_W,
    localparam int SH_W   = $clog2(WORD_W) + 1,
    localparam int IDX_W  = $clog2(LANE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        mode,
    input  logic [LANE_W-1:0] a_odd,
    input  logic [LANE_W-1:0] a_even,
    input  logic [LANE_W-1:0] b_odd,
    input  logic [LANE_W-1:0] b_even,
    input  logic              use_imm,
    input  logic [LANE_W-1:0] imm,
    input  logic [SH_W-1:0]   shamt,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic [1:0]        flag_c,
    output logic [1:0]        flag_v,
    output logic              flag_t,
    output logic              illegal
);
    logic [WORD_W-1:0] a_w, b_w, sum_w, shf_w, raw_w, res_c;
    logic [LANE_W-1:0] bit_res;
    logic              bit_t, shf_bad;
    logic              sub_op, cin_lo, cin_hi;
    logic [1:0]        lane_c, lane_v;
    logic [1:0]        c_c, v_c;
    logic              t_c, z_c, n_c, ill_c;

    // operand assembly: odd register is the upper half
    always_comb begin
        a_w = {a_odd, a_even};
        if (!use_imm)
            b_w = {b_odd, b_even};
        else if (mode == MODE_DUAL)
            b_w = {imm, imm};
        else
            b_w = {{LANE_W{imm[LANE_W-1]}}, imm};
    end

    assign sub_op = (op == OP_SUB);
    assign cin_lo = sub_op;
    assign cin_hi = (mode == MODE_WIDE) ? lane_c[0] : sub_op;

    for (genvar g = 0; g < 2; g++) begin : g_add
        lane_addsub #(.W(LANE_W)) u_lane (
            .a    (a_w[g*LANE_W +: LANE_W]),
            .b    (b_w[g*LANE_W +: LANE_W]),
            .sub  (sub_op),
            .cin  ((g == 0) ? cin_lo : cin_hi),
            .sum  (sum_w[g*LANE_W +: LANE_W]),
            .cout (lane_c[g]),
            .ovf  (lane_v[g])
        );
    end

    simd_shifter #(.LANE_W(LANE_W)) u_shift (
        .mode         (mode),
        .din          (a_w),
        .amt          (shamt),
        .dout         (shf_w),
        .out_of_range (shf_bad)
    );

    bit_unit #(.LANE_W(LANE_W)) u_bits (
        .sub_op (op[1:0]),
        .din    (a_even),
        .idx    (shamt[IDX_W-1:0]),
        .dout   (bit_res),
        .tbit   (bit_t)
    );

    // result select, legality and flags
    always_comb begin
        raw_w = '0;
        c_c   = '0;
        v_c   = '0;
        t_c   = 1'b0;
        ill_c = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                raw_w = sum_w;
                unique case (mode)
                    MODE_WIDE: begin c_c[0] = lane_c[1]; v_c[0] = lane_v[1]; end
                    MODE_DUAL: begin c_c = lane_c; v_c = lane_v; end
                    default:   begin c_c[0] = lane_c[0]; v_c[0] = lane_v[0]; end
                endcase
            end
            OP_AND:   raw_w = a_w & b_w;
            OP_OR:    raw_w = a_w | b_w;
            OP_XOR:   raw_w = a_w ^ b_w;
            OP_SHIFT: begin
                raw_w = shf_w;
                ill_c = shf_bad;
            end
            OP_BSET, OP_BCLR, OP_BTGL, OP_BTST: begin
                raw_w = {{LANE_W{1'b0}}, bit_res};
                t_c   = bit_t;
                ill_c = (mode != MODE_NARROW);
            end
            default: ill_c = 1'b1;
        endcase
        if (mode == 2'd3)
            ill_c = 1'b1;

        res_c = (mode == MODE_NARROW) ? {{LANE_W{1'b0}}, raw_w[LANE_W-1:0]} : raw_w;
        if (ill_c) begin
            res_c = '0;
            c_c   = '0;
            v_c   = '0;
            t_c   = 1'b0;
        end
        z_c = !ill_c && (res_c == '0);
        n_c = (mode == MODE_NARROW) ? res_c[LANE_W-1] : res_c[WORD_W-1];
    end

    // registered output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_z    <= 1'b0;
            flag_n    <= 1'b0;
            flag_c    <= '0;
            flag_v    <= '0;
            flag_t    <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= res_c;
                flag_z  <= z_c;
                flag_n  <= n_c;
                flag_c  <= c_c;
                flag_v  <= v_c;
                flag_t  <= t_c;
                illegal <= ill_c;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |->
        (result == '0 && !flag_z && !flag_n && flag_c == 2'b00 && flag_v == 2'b00 && !flag_t));

    // R11
    btst_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BTST && mode == MODE_NARROW) |=>
        (result == {{LANE_W{1'b0}}, $past(a_even)} && !illegal));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_NARROW) |=> (result[WORD_W-1:LANE_W] == '0));

    // R5
    scalar_flag_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != MODE_DUAL) |=> (!flag_c[1] && !flag_v[1]));
endmodule

// File: tb/test_dmsimd_alu.sv
module test_dmsimd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  mode = '0;
    logic [15:0] a_odd = '0, a_even = '0, b_odd = '0, b_even = '0, imm = '0;
    logic        use_imm = 1'b0;
    logic [5:0]  shamt = '0;
    logic        out_valid, flag_z, flag_n, flag_t, illegal;
    logic [31:0] result;
    logic [1:0]  flag_c, flag_v;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmsimd_alu i_dmsimd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
        .a_odd(a_odd), .a_even(a_even), .b_odd(b_odd), .b_even(b_even),
        .use_imm(use_imm), .imm(imm), .shamt(shamt),
        .out_valid(out_valid), .result(result), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v), .flag_t(flag_t), .illegal(illegal)
    );

    // expected {illegal,z,n,c[1:0],v[1:0],t,result[31:0]}
    function automatic logic [39:0] ref_calc(
        input logic [3:0] f_op, input logic [1:0] md,
        input logic [15:0] ah, input logic [15:0] al,
        input logic [15:0] bh, input logic [15:0] bl,
        input logic ui, input logic [15:0] im, input logic [5:0] sa);
        logic [31:0] a, b, bb, r;
        logic [32:0] s33;
        logic [16:0] s17;
        logic [15:0] la, lb, lr, msk;
        logic [1:0]  c, v;
        logic        t, ill, cin;
        int          amt, mag;
        a = {ah, al};
        b = {bh, bl};
        if (ui) b = (md == 2'd2) ? {im, im} : {{16{im[15]}}, im};
        r = '0; c = '0; v = '0; t = 1'b0; ill = 1'b0;
        amt = sa[5] ? (int'(sa) - 64) : int'(sa);
        mag = (amt < 0) ? -amt : amt;
        case (f_op)
            4'd0, 4'd1: begin
                cin = f_op[0];
                bb  = cin ? ~b : b;
                if (md == 2'd1) begin
                    s33  = {1'b0, a} + {1'b0, bb} + {32'd0, cin};
                    r    = s33[31:0];
                    c[0] = s33[32];
                    v[0] = (a[31] == bb[31]) && (r[31] != a[31]);
                end else begin
                    for (int l = 0; l < 2; l++) begin
                        la = a[l*16 +: 16];
                        lb = bb[l*16 +: 16];
                        s17 = {1'b0, la} + {1'b0, lb} + {16'd0, cin};
                        r[l*16 +: 16] = s17[15:0];
                        c[l] = s17[16];
                        v[l] = (la[15] == lb[15]) && (s17[15] != la[15]);
                    end
                    if (md == 2'd0) begin c[1] = 1'b0; v[1] = 1'b0; end
                end
            end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: begin
                if (md == 2'd1) begin
                    ill = (mag > 31);
                    r = (amt < 0) ? 32'($signed(a) >>> mag) : (a << mag);
                end else begin
                    ill = (mag > 15);
                    for (int l = 0; l < 2; l++) begin
                        la = a[l*16 +: 16];
                        lr = (amt < 0) ? 16'($signed(la) >>> mag) : (la << mag);
                        r[l*16 +: 16] = lr;
                    end
                end
            end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                ill = (md != 2'd0);
                msk = 16'd1 << sa[3:0];
                case (f_op)
                    4'd8:  r = {16'd0, al | msk};
                    4'd9:  r = {16'd0, al & ~msk};
                    4'd10: r = {16'd0, al ^ msk};
                    default: begin r = {16'd0, al}; t = |(al & msk); end
                endcase
            end
            default: ill = 1'b1;
        endcase
        if (md == 2'd3) ill = 1'b1;
        if (md == 2'd0) r[31:16] = '0;
        if (ill) return {1'b1, 7'd0, 32'd0};
        return {1'b0, (r == 32'd0), (md == 2'd0) ? r[15] : r[31], c, v, t, r};
    endfunction

    function automatic string tag_of(input logic [3:0] f_op, input logic [1:0] md);
        if (md == 2'd3) return "R12";
        case (f_op)
            4'd0, 4'd1: return (md == 2'd2) ? "R4" : "R3";
            4'd2, 4'd3, 4'd4: return "R7";
            4'd5: return "R8";
            4'd8, 4'd9, 4'd10: return (md == 2'd0) ? "R10" : "R12";
            4'd11: return (md == 2'd0) ? "R11" : "R12";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] f_op, input logic [1:0] md,
                         input logic [15:0] ah, input logic [15:0] al,
                         input logic [15:0] bh, input logic [15:0] bl,
                         input logic ui, input logic [15:0] im, input logic [5:0] sa,
                         input string tag);
        logic [39:0] exp;
        @(negedge clk);
        op = f_op; mode = md; a_odd = ah; a_even = al; b_odd = bh; b_even = bl;
        use_imm = ui; imm = im; shamt = sa; in_valid = 1'b1;
        exp = ref_calc(f_op, md, ah, al, bh, bl, ui, im, sa);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {illegal, flag_z, flag_n, flag_c, flag_v, flag_t, result}, exp);
        check("R1", {31'd0, out_valid}, 40'd1);
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom % 6)
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [10];
        ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd11};
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {out_valid, illegal, flag_z, flag_n, flag_c, flag_v, flag_t, result}, 41'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 40'd0);

        // directed corner cases
        apply(4'd0, 2'd2, 16'h0000, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, 16'h0, 6'd0, "R4");
        check("R4", {result, 6'd0, flag_c}, {32'h0000_0000, 6'd0, 2'b01});
        apply(4'd0, 2'd1, 16'h0000, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, 16'h0, 6'd0, "R2");
        check("R2", {8'd0, result}, {8'd0, 32'h0001_0000});
        apply(4'd0, 2'd0, 16'h1234, 16'h7FFF, 16'h0000, 16'h0001, 1'b0, 16'h0, 6'd0, "R5");
        check("R5", {result, 6'd0, flag_v}, {32'h0000_8000, 6'd0, 2'b01});
        apply(4'd1, 2'd0, 16'h0, 16'h0005, 16'h0, 16'h0005, 1'b0, 16'h0, 6'd0, "R6");
        check("R6", {38'd0, flag_z, flag_c[0]}, {38'd0, 1'b1, 1'b1});
        apply(4'd1, 2'd2, 16'h8000, 16'h0000, 16'h0001, 16'h0001, 1'b0, 16'h0, 6'd0, "R4");
        apply(4'd5, 2'd0, 16'h0, 16'h8000, 16'h0, 16'h0, 1'b0, 16'h0, 6'b110001, "R8");
        check("R8", {8'd0, result}, {8'd0, 32'h0000_FFFF});
        apply(4'd5, 2'd2, 16'h8001, 16'h4000, 16'h0, 16'h0, 1'b0, 16'h0, 6'd1, "R8");
        apply(4'd5, 2'd0, 16'h0, 16'h0001, 16'h0, 16'h0, 1'b0, 16'h0, 6'd16, "R9");
        check("R9", {39'd0, illegal}, 40'd1);
        apply(4'd5, 2'd1, 16'h8000, 16'h0, 16'h0, 16'h0, 1'b0, 16'h0, 6'b100000, "R9");
        check("R9", {39'd0, illegal}, 40'd1);
        apply(4'd5, 2'd1, 16'h8000, 16'h0, 16'h0, 16'h0, 1'b0, 16'h0, 6'b100001, "R9");
        check("R9", {8'd0, result}, {8'd0, 32'hFFFF_FFFF});
        apply(4'd8, 2'd0, 16'h0, 16'h0000, 16'h0, 16'h0, 1'b0, 16'h0, 6'b110011, "R10");
        check("R10", {8'd0, result}, {8'd0, 32'h0000_0008});
        apply(4'd11, 2'd0, 16'h0, 16'hA5A5, 16'h0, 16'h0, 1'b0, 16'h0, 6'd2, "R11");
        check("R11", {7'd0, flag_t, result}, {7'd0, 1'b1, 32'h0000_A5A5});
        apply(4'd8, 2'd1, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 16'h0, 6'd0, "R12");
        apply(4'd9, 2'd2, 16'h0, 16'hFFFF, 16'h0, 16'h0, 1'b0, 16'h0, 6'd0, "R12");
        apply(4'd0, 2'd3, 16'h1, 16'h1, 16'h1, 16'h1, 1'b0, 16'h0, 6'd0, "R12");
        apply(4'd6, 2'd0, 16'h1, 16'h1, 16'h1, 16'h1, 1'b0, 16'h0, 6'd0, "R12");
        apply(4'd0, 2'd1, 16'h0000, 16'h0001, 16'h5555, 16'h5555, 1'b1, 16'hFFFF, 6'd0, "R13");
        check("R13", {8'd0, result}, {8'd0, 32'h0000_0000});
        apply(4'd0, 2'd2, 16'h0001, 16'h0002, 16'h5555, 16'h5555, 1'b1, 16'h0010, 6'd0, "R13");
        check("R13", {8'd0, result}, {8'd0, 32'h0011_0012});

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [3:0] r_op;
            logic [1:0] r_md;
            r_op = ($urandom % 10 == 0) ? 4'($urandom) : ops[$urandom % 10];
            r_md = ($urandom % 12 == 0) ? 2'd3 : 2'($urandom % 3);
            apply(r_op, r_md, pick16(), pick16(), pick16(), pick16(),
                  ($urandom % 4 == 0), pick16(), 6'($urandom), tag_of(r_op, r_md));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule